// File: doc/BRIEF.md
# Edge-Selectable External Event Counter

This block tallies pulses that arrive on an asynchronous event pin. The pin is first brought into the system clock domain. A chosen transition (low-to-high or high-to-low) is then turned into a single-cycle count strobe. Each strobe advances a counter.

The counter is compared against a programmable limit. When a strobe arrives while the count already equals the limit, the counter returns to zero and a one-cycle interrupt pulse is raised. This repeats on every pass, so the interrupt marks each group of (limit + 1) events. A run bit gates the whole counter: with it low, the count is held at zero.

The limit may lie anywhere in the full counter range. If the count is already above a newly lowered limit, it runs up to its top value and rolls over before it can meet the limit again.

Top module: `edge_event_counter`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, the next cycle shows `count` = 0 and `match_irq` = 0.
- R2: An event input held steady through reset and afterwards is never taken as an edge; `count` stays at 0.
- R3: With `edge_sel` = 2'b00, each low-to-high transition of `evt_in` raises `count` by exactly one, and high-to-low transitions have no effect.
- R4: With `edge_sel` = 2'b01, each high-to-low transition of `evt_in` raises `count` by one, and low-to-high transitions have no effect.
- R5: With `edge_sel` = 2'b10 or 2'b11, no transition is counted and `count` holds its value.
- R6: A new `evt_in` level first sampled at clock edge k shows its effect on `count` right after edge k+2, and not earlier.
- R7: A valid edge that arrives while `count` equals `cmp_val` sets `count` to 0 and raises `match_irq` for exactly one cycle, in the same cycle that `count` reads 0.
- R8: The interrupt recurs on every later match, once every `cmp_val`+1 valid edges.
- R9: With `cmp_val` = 0, every valid edge raises `match_irq`, and `count` stays at 0.
- R10: With `count_en` low, `count` reads 0 after the next clock edge, edges are ignored, and no interrupt is raised.
- R11: A count above `cmp_val` keeps rising, rolls over from 255 to 0 with no interrupt, and then matches normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Asynchronous external event pin |
| edge_sel | input | 2 | Valid-edge code: 00 rising, 01 falling, others count nothing |
| count_en | input | 1 | Run bit; low holds the count at zero |
| cmp_val | input | 8 | Compare limit |
| count | output | 8 | Current event count |
| match_irq | output | 1 | One-cycle pulse on compare match |

## Verification
The bench uses the default parameters: an 8-bit counter and a two-stage synchroniser. At this width, both the 255-to-0 rollover and a limit of 255 can be reached with a few hundred pulses. The two-stage depth gives the exact two-edge latency that the reference model tracks from its own sample history. The same depth also sets the warm-up window that the held-high-through-reset case probes.

// File: rtl/evc_pkg.sv
// Package: shared types for the edge-selectable event counter.
// Assumes: edge select codes are fixed by the programming model (00 rise, 01 fall).
package evc_pkg;

    // Valid-edge selection codes seen on the edge_sel port
    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_RSV_A = 2'b10,
        EDGE_RSV_B = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/evc_sync.sv
// Module: evc_sync
// Brings the asynchronous event pin into the clk domain through a chain of
// STAGES flops. Assumes STAGES >= 2; output lags the pin by STAGES edges.
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop captures the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Later flops let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/evc_edge_det.sv
// Module: evc_edge_det
// Compares the synchronised level with its previous sample and emits a
// one-cycle strobe for the selected transition. A warm-up register blocks
// strobes until the synchroniser and history hold real pin samples, so an
// input held high through reset is not mistaken for an edge.
// Assumes: level comes from an evc_sync of depth SYNC_STAGES.
module evc_edge_det
    import evc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  edge_mode_e mode,
    output logic       strobe
);

    localparam int WARM_W = SYNC_STAGES + 1;

    logic              prev_q;
    logic [WARM_W-1:0] warm_q;
    logic              primed;
    logic              rise;
    logic              fall;

    // Keep the previous synchronised level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Shift ones in after reset until every stage holds a real sample
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= {warm_q[WARM_W-2:0], 1'b1};
    end

    assign primed = warm_q[WARM_W-1];
    assign rise   = level & ~prev_q;
    assign fall   = ~level & prev_q;

    // Pick the transition selected by the mode code
    always_comb begin
        strobe = 1'b0;
        if (primed) begin
            case (mode)
                EDGE_RISE: strobe = rise;
                EDGE_FALL: strobe = fall;
                default:   strobe = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/evc_count_core.sv
// Module: evc_count_core
// Counter with compare-and-clear. On a strobe it either advances by one or,
// when already equal to the limit, returns to zero and raises a registered
// one-cycle interrupt. The run bit low forces the count to zero.
// Assumes: strobe is a single-cycle pulse in the clk domain.
module evc_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             strobe,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             irq_q;
    logic             hit;

    assign hit = (count_q == limit);

    // Advance, clear on match, or hold at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!run) begin
                count_q <= '0;
            end else if (strobe) begin
                if (hit) begin
                    count_q <= '0;
                    irq_q   <= 1'b1;
                end else begin
                    count_q <= count_q + ONE;
                end
            end
        end
    end

    assign count = count_q;
    assign irq   = irq_q;

endmodule

// File: rtl/edge_event_counter.sv
// Module: edge_event_counter (top)
// External event counter: synchronises the event pin, detects the chosen
// edge and counts it against a compare limit with clear-on-match and a
// one-cycle interrupt. Assumes SYNC_STAGES >= 2.
module edge_event_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic [1:0]       edge_sel,
    input  logic             count_en,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             match_irq
);

    logic       evt_sync;
    logic       evt_strobe;
    edge_mode_e mode;

    assign mode = edge_mode_e'(edge_sel);

    evc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (evt_in),
        .sync_out (evt_sync)
    );

    evc_edge_det #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (evt_sync),
        .mode   (mode),
        .strobe (evt_strobe)
    );

    evc_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (count_en),
        .strobe (evt_strobe),
        .limit  (cmp_val),
        .count  (count),
        .irq    (match_irq)
    );

endmodule

// File: rtl/evc_checker.sv
// Module: evc_checker
// Temporal properties of the event counter, bound to the top module.
module evc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             count_en,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] count,
    input logic             match_irq
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !match_irq)); // R1

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == '0 || count == CNT_W'($past(count) + 1'b1))); // R3

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq); // R7

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> (count == '0 && $past(count) == $past(cmp_val))); // R7

    AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (count == '0 && !match_irq)); // R10

    AST_ROLLOVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == TOP && $past(cmp_val) != TOP && count == '0) |-> !match_irq); // R11

endmodule

bind edge_event_counter evc_checker #(.CNT_W(CNT_W)) u_evc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .cmp_val   (cmp_val),
    .count     (count),
    .match_irq (match_irq)
);

// File: tb/tb_edge_event_counter.sv
// Bench: behavioural reference model compared every clock plus directed checks.
module tb_edge_event_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_in = 1'b1;
    logic [1:0] edge_sel = 2'b00;
    logic       count_en = 1'b1;
    logic [7:0] cmp_val = 8'd5;
    logic [7:0] count;
    logic       match_irq;

    int tests = 0;
    int fails = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    // Reference model state
    bit hist[$];
    int m_count = 0;
    bit m_irq = 1'b0;

    always #4 clk = ~clk;

    edge_event_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .edge_sel  (edge_sel),
        .count_en  (count_en),
        .cmp_val   (cmp_val),
        .count     (count),
        .match_irq (match_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model: the level sampled two edges back versus three edges back decides the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_count = 0;
            m_irq = 1'b0;
        end else begin
            bit s_now, s_old, edge_ok;
            hist.push_back(evt_in);
            if (hist.size() > 4) void'(hist.pop_front());
            m_irq = 1'b0;
            edge_ok = 1'b0;
            if (hist.size() >= 4) begin
                s_now = hist[hist.size()-3];
                s_old = hist[hist.size()-4];
                if (edge_sel == 2'b00) edge_ok = s_now & ~s_old;
                else if (edge_sel == 2'b01) edge_ok = ~s_now & s_old;
            end
            if (!count_en) m_count = 0;
            else if (edge_ok) begin
                if (m_count == int'(cmp_val)) begin
                    m_count = 0;
                    m_irq = 1'b1;
                end else m_count = (m_count + 1) % 256;
            end
        end
    end

    // Compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R6 model count", int'(count), m_count);
            chk("R7 model irq", int'(match_irq), int'(m_irq));
            if (match_irq) irq_seen++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1;
            cycles(3);
            evt_in = 1'b0;
            cycles(3);
        end
    endtask

    initial begin
        int base;
        cycles(4);
        chk("R1 reset count", int'(count), 0);
        chk("R1 reset irq", int'(match_irq), 0);
        rst_n = 1'b1;
        cycles(10);
        chk("R2 held input no edge", int'(count), 0);
        evt_in = 1'b0;
        cmp_val = 8'd20;
        cycles(6);

        pulses(5);
        chk("R3 rising count", int'(count), 5);
        evt_in = 1'b1;
        cycles(6);
        chk("R3 rise adds one", int'(count), 6);
        evt_in = 1'b0;
        cycles(6);
        chk("R3 fall ignored", int'(count), 6);

        edge_sel = 2'b01;
        evt_in = 1'b1;
        cycles(6);
        chk("R4 rise ignored", int'(count), 6);
        evt_in = 1'b0;
        cycles(6);
        chk("R4 fall counted", int'(count), 7);

        edge_sel = 2'b10;
        pulses(3);
        chk("R5 code 10 holds", int'(count), 7);
        edge_sel = 2'b11;
        pulses(3);
        chk("R5 code 11 holds", int'(count), 7);
        edge_sel = 2'b00;

        evt_in = 1'b1;
        cycles(2);
        chk("R6 no early change", int'(count), 7);
        cycles(1);
        chk("R6 change after two edges", int'(count), 8);
        evt_in = 1'b0;
        cycles(4);

        cmp_val = 8'd9;
        base = irq_seen;
        pulses(1);
        chk("R7 at limit", int'(count), 9);
        pulses(1);
        chk("R7 cleared", int'(count), 0);
        chk("R7 one irq", irq_seen - base, 1);
        pulses(20);
        chk("R8 recurring irqs", irq_seen - base, 3);
        chk("R8 count back to zero", int'(count), 0);

        cmp_val = 8'd0;
        base = irq_seen;
        pulses(4);
        chk("R9 zero limit count", int'(count), 0);
        chk("R9 zero limit irqs", irq_seen - base, 4);

        cmp_val = 8'd50;
        pulses(3);
        chk("R10 pre-stop count", int'(count), 3);
        count_en = 1'b0;
        cycles(2);
        chk("R10 stop clears", int'(count), 0);
        base = irq_seen;
        pulses(3);
        chk("R10 edges ignored", int'(count), 0);
        chk("R10 no irq", irq_seen - base, 0);
        count_en = 1'b1;
        cycles(2);

        cmp_val = 8'd100;
        pulses(10);
        chk("R11 setup", int'(count), 10);
        cmp_val = 8'd3;
        base = irq_seen;
        pulses(245);
        chk("R11 reach top", int'(count), 255);
        pulses(1);
        chk("R11 rollover count", int'(count), 0);
        chk("R11 rollover no irq", irq_seen - base, 0);
        pulses(4);
        chk("R11 match after roll", int'(count), 0);
        chk("R11 irq after roll", irq_seen - base, 1);

        cmp_val = 8'd255;
        base = irq_seen;
        pulses(255);
        chk("R7 limit 255 reach", int'(count), 255);
        pulses(1);
        chk("R7 limit 255 clear", int'(count), 0);
        chk("R7 limit 255 irq", irq_seen - base, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule